// File: doc/BRIEF.md
# Audio Stream Interface Controller

This block is the register front end of a streaming audio output. A processor reaches it over a simple 32-bit register bus with four word addresses. Through this bus it can enable playback, pick one of two stream sample rates, and set a left and right volume. It can also program a trigger count and acknowledge an interrupt. While playback is enabled, a sample counter advances once for every strobe of the selected rate. When the counter steps onto the trigger value, an interrupt status flag is raised, provided the trigger is armed.

The block has two strobe inputs, one for each rate. The 32 kHz strobe is used when the rate bit is 0 and the 48 kHz strobe when it is 1. A separate rate flag for the DMA side is only stored here; its meaning is inverted, so 0 means 48 kHz and 1 means 32 kHz. Software clears the counter by writing a control bit that clears itself. It acknowledges the interrupt by writing 1 to the status bit. The interrupt output is the status flag gated by an enable bit.

Top module: `aud_stream_ctl`

## Requirements
- R1: After reset every register reads 0 and `irq` is low.
- R2: Word address 0 is control, 1 is volume, 2 is sample count and 3 is trigger. In control, bit 0 is play, bit 1 is stream rate, bit 2 is interrupt enable, bit 3 is interrupt status, bit 4 is trigger armed, bit 5 is counter clear and bit 6 is DMA rate. All other control bits read 0. Volume keeps bits 15:0, with left in 7:0 and right in 15:8; bits 31:16 read 0.
- R3: While play is 1, the counter goes up by exactly one on each cycle where the strobe of the selected rate is high. Rate 0 selects `strobe_lo` and rate 1 selects `strobe_hi`. The strobe of the other rate is ignored.
- R4: While play is 0, the counter holds its value whatever the strobes do.
- R5: Writing control with bit 5 set makes the counter read 0 from the next cycle on. This holds even when a counting strobe arrives in the same cycle. Bit 5 always reads 0.
- R6: Writes to address 2 are ignored. The count and trigger registers are 31 bits wide, and bit 31 of both reads 0.
- R7: The status bit becomes 1 after the cycle in which the counter steps onto the trigger value, but only while the armed bit is 1. With armed at 0 it stays 0.
- R8: Writing 1 to status bit 3 clears it, and writing 0 there leaves it unchanged. If a new trigger match and the clearing write fall in the same cycle, the status bit stays 1.
- R9: `irq` is high exactly when the status bit and the interrupt enable bit are both 1.
- R10: The DMA rate bit 6 is stored and read back, and has no effect on counting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access this cycle |
| bus_we | input | 1 | Write when high, with bus_sel |
| bus_addr | input | 2 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| strobe_lo | input | 1 | One-cycle sample strobe, 32 kHz rate |
| strobe_hi | input | 1 | One-cycle sample strobe, 48 kHz rate |
| irq | output | 1 | Interrupt request |

## Verification
The hardest situations to reach are same-cycle collisions. In one, a counter-clear write meets a counting strobe. In the other, an acknowledge write meets the strobe that steps the counter onto the trigger. Neither collision can happen through separate bus accesses. The bench therefore has a task that drives a strobe and a control write at the same falling edge, so both reach the same rising edge. It first walks the counter to one step below the trigger with single strobes.

// File: rtl/aud_pkg.sv
package aud_pkg;
  localparam logic [1:0] ADDR_CTL = 2'd0;
  localparam logic [1:0] ADDR_VOL = 2'd1;
  localparam logic [1:0] ADDR_CNT = 2'd2;
  localparam logic [1:0] ADDR_TRG = 2'd3;

  localparam int B_PLAY  = 0;
  localparam int B_SRATE = 1;
  localparam int B_IEN   = 2;
  localparam int B_ISTAT = 3;
  localparam int B_ARM   = 4;
  localparam int B_CLR   = 5;
  localparam int B_DRATE = 6;

  typedef struct packed {
    logic drate;
    logic arm;
    logic ien;
    logic srate;
    logic play;
  } ctl_t;
endpackage

// File: rtl/aud_reg_file.sv
module aud_reg_file
  import aud_pkg::*;
#(
  parameter int DW    = 32,
  parameter int VOL_W = 16,
  parameter int TRG_W = 31
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_sel,
  input  logic             bus_we,
  input  logic [1:0]       bus_addr,
  input  logic [DW-1:0]    bus_wdata,
  output ctl_t             ctl,
  output logic [VOL_W-1:0] vol,
  output logic [TRG_W-1:0] trig,
  output logic             cnt_clr,
  output logic             stat_ack
);
  logic wr_ctl, wr_vol, wr_trg;
  ctl_t ctl_d, ctl_q;
  logic [VOL_W-1:0] vol_d, vol_q;
  logic [TRG_W-1:0] trg_d, trg_q;
  logic unused_wd;

  assign wr_ctl = bus_sel & bus_we & (bus_addr == ADDR_CTL);
  assign wr_vol = bus_sel & bus_we & (bus_addr == ADDR_VOL);
  assign wr_trg = bus_sel & bus_we & (bus_addr == ADDR_TRG);
  assign unused_wd = ^bus_wdata;

  always_comb begin
    ctl_d = ctl_q;
    if (wr_ctl) begin
      ctl_d.play  = bus_wdata[B_PLAY];
      ctl_d.srate = bus_wdata[B_SRATE];
      ctl_d.ien   = bus_wdata[B_IEN];
      ctl_d.arm   = bus_wdata[B_ARM];
      ctl_d.drate = bus_wdata[B_DRATE];
    end
    vol_d = wr_vol ? bus_wdata[VOL_W-1:0] : vol_q;
    trg_d = wr_trg ? bus_wdata[TRG_W-1:0] : trg_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q <= '0;
      vol_q <= '0;
      trg_q <= '0;
    end else begin
      ctl_q <= ctl_d;
      vol_q <= vol_d;
      trg_q <= trg_d;
    end
  end

  assign ctl      = ctl_q;
  assign vol      = vol_q;
  assign trig     = trg_q;
  assign cnt_clr  = wr_ctl & bus_wdata[B_CLR];
  assign stat_ack = wr_ctl & bus_wdata[B_ISTAT];
endmodule

// File: rtl/aud_sample_cnt.sv
module aud_sample_cnt #(
  parameter int CW = 31
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          play,
  input  logic          rate_sel,
  input  logic          strobe_lo,
  input  logic          strobe_hi,
  input  logic          clr,
  output logic [CW-1:0] cnt,
  output logic [CW-1:0] cnt_nxt,
  output logic          step
);
  logic          strb;
  logic [CW-1:0] cnt_d, cnt_q;

  assign strb    = rate_sel ? strobe_hi : strobe_lo;
  assign step    = play & strb & ~clr;
  assign cnt_nxt = cnt_q + CW'(1);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)       cnt_d = '0;
    else if (step) cnt_d = cnt_nxt;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;
endmodule

// File: rtl/aud_irq_unit.sv
module aud_irq_unit (
  input  logic clk,
  input  logic rst_n,
  input  logic set_req,
  input  logic ack,
  input  logic ien,
  output logic stat,
  output logic irq
);
  logic stat_d, stat_q;

  always_comb begin
    stat_d = stat_q;
    if (set_req)  stat_d = 1'b1;
    else if (ack) stat_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stat_q <= 1'b0;
    else        stat_q <= stat_d;
  end

  assign stat = stat_q;
  assign irq  = stat_q & ien;
endmodule

// File: rtl/aud_stream_ctl.sv
module aud_stream_ctl
  import aud_pkg::*;
#(
  parameter int DW    = 32,
  parameter int CW    = 31,
  parameter int VOL_W = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_sel,
  input  logic          bus_we,
  input  logic [1:0]    bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  input  logic          strobe_lo,
  input  logic          strobe_hi,
  output logic          irq
);
  localparam int CNT_PAD = DW - CW;
  localparam int VOL_PAD = DW - VOL_W;

  ctl_t             ctl;
  logic [VOL_W-1:0] vol;
  logic [CW-1:0]    trig, cnt, cnt_nxt;
  logic             cnt_clr, stat_ack, step, stat, hit;

  aud_reg_file #(.DW(DW), .VOL_W(VOL_W), .TRG_W(CW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .ctl(ctl), .vol(vol),
    .trig(trig), .cnt_clr(cnt_clr), .stat_ack(stat_ack)
  );

  aud_sample_cnt #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .play(ctl.play), .rate_sel(ctl.srate),
    .strobe_lo(strobe_lo), .strobe_hi(strobe_hi), .clr(cnt_clr),
    .cnt(cnt), .cnt_nxt(cnt_nxt), .step(step)
  );

  assign hit = step & ctl.arm & (cnt_nxt == trig);

  aud_irq_unit u_irq (
    .clk(clk), .rst_n(rst_n), .set_req(hit), .ack(stat_ack),
    .ien(ctl.ien), .stat(stat), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_CTL: begin
        bus_rdata[B_PLAY]  = ctl.play;
        bus_rdata[B_SRATE] = ctl.srate;
        bus_rdata[B_IEN]   = ctl.ien;
        bus_rdata[B_ISTAT] = stat;
        bus_rdata[B_ARM]   = ctl.arm;
        bus_rdata[B_DRATE] = ctl.drate;
      end
      ADDR_VOL: bus_rdata = {{VOL_PAD{1'b0}}, vol};
      ADDR_CNT: bus_rdata = {{CNT_PAD{1'b0}}, cnt};
      default:  bus_rdata = {{CNT_PAD{1'b0}}, trig};
    endcase
  end
endmodule

// File: rtl/aud_stream_ctl_chk.sv
module aud_stream_ctl_chk #(
  parameter int DW = 32,
  parameter int CW = 31
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_sel,
  input logic          bus_we,
  input logic [1:0]    bus_addr,
  input logic [DW-1:0] bus_wdata,
  input logic [CW-1:0] cnt,
  input logic [CW-1:0] trig,
  input logic          step,
  input logic          play,
  input logic          arm,
  input logic          ien,
  input logic          stat,
  input logic          irq
);
  logic clr_wr, ack_wr;
  assign clr_wr = bus_sel && bus_we && (bus_addr == 2'd0) && bus_wdata[5];
  assign ack_wr = bus_sel && bus_we && (bus_addr == 2'd0) && bus_wdata[3];

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> (cnt == $past(cnt) || cnt == $past(cnt) + CW'(1)));

  a_r4_hold_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!play && !clr_wr) |=> (cnt == $past(cnt)));

  a_r5_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr_wr |=> (cnt == '0));

  a_r7_status_set: assert property (@(posedge clk) disable iff (!rst_n)
    (step && arm && (cnt + CW'(1) == trig)) |=> stat);

  a_r8_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_wr && !step) |=> !stat);

  a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    !ien |-> !irq);

  a_r9_irq_needs_status: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> stat);
endmodule

bind aud_stream_ctl aud_stream_ctl_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .cnt(cnt), .trig(trig),
  .step(step), .play(ctl.play), .arm(ctl.arm), .ien(ctl.ien),
  .stat(stat), .irq(irq)
);

// File: tb/aud_stream_ctl_test.sv
module aud_stream_ctl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_we = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        strobe_lo = 1'b0, strobe_hi = 1'b0;
  logic        irq;
  int          total = 0, bad = 0;

  always #2 clk = ~clk;

  aud_stream_ctl uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .strobe_lo(strobe_lo), .strobe_hi(strobe_hi), .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic pulse(input logic lo, input logic hi);
    @(negedge clk);
    strobe_lo = lo; strobe_hi = hi;
    @(negedge clk);
    strobe_lo = 1'b0; strobe_hi = 1'b0;
  endtask

  // strobe and control write reach the same rising edge
  task automatic wr_with_strobe(input logic [31:0] d, input logic lo, input logic hi);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = 2'd0; bus_wdata = d;
    strobe_lo = lo; strobe_hi = hi;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = '0;
    strobe_lo = 1'b0; strobe_hi = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a < 4; a++) begin
      rd(2'(a), v);
      chk("R1 reset value", v, 32'h0);
    end
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_regs();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0056);
    rd(2'd0, v); chk("R2 control readback", v, 32'h0000_0056);
    chk("R10 dma rate bit stored", {31'b0, v[6]}, 32'h1);
    wr(2'd0, 32'hFFFF_FFFF);
    rd(2'd0, v); chk("R2/R5 control all ones", v, 32'h0000_0057);
    wr(2'd0, 32'h0);
    rd(2'd0, v); chk("R2 control cleared", v, 32'h0);
    wr(2'd1, 32'hABCD_1234);
    rd(2'd1, v); chk("R2 volume upper zero", v, 32'h0000_1234);
    chk("R2 volume left", {24'b0, v[7:0]}, 32'h34);
    chk("R2 volume right", {24'b0, v[15:8]}, 32'h12);
    wr(2'd3, 32'hFFFF_FFFF);
    rd(2'd3, v); chk("R6 trigger bit31 zero", v, 32'h7FFF_FFFF);
    wr(2'd3, 32'h0);
  endtask

  task automatic t_count_rate();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0021);
    repeat (3) pulse(1'b1, 1'b0);
    repeat (2) pulse(1'b0, 1'b1);
    rd(2'd2, v); chk("R3 rate 0 counts lo only", v, 32'd3);
    wr(2'd0, 32'h0000_0003);
    repeat (2) pulse(1'b0, 1'b1);
    pulse(1'b1, 1'b0);
    rd(2'd2, v); chk("R3 rate 1 counts hi only", v, 32'd5);
    pulse(1'b1, 1'b1);
    rd(2'd2, v); chk("R3 both strobes one step", v, 32'd6);
  endtask

  task automatic t_hold();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0002);
    repeat (4) pulse(1'b1, 1'b1);
    rd(2'd2, v); chk("R4 hold when stopped", v, 32'd6);
    wr(2'd0, 32'h0000_0043);
    pulse(1'b0, 1'b1);
    rd(2'd2, v); chk("R10 dma rate no effect", v, 32'd7);
  endtask

  task automatic t_clear();
    logic [31:0] v;
    wr(2'd0, 32'h0000_0023);
    rd(2'd2, v); chk("R5 clear zeroes count", v, 32'd0);
    rd(2'd0, v); chk("R5 clear bit reads 0", v, 32'h0000_0003);
    repeat (2) pulse(1'b0, 1'b1);
    wr_with_strobe(32'h0000_0023, 1'b0, 1'b1);
    rd(2'd2, v); chk("R5 clear beats strobe", v, 32'd0);
  endtask

  task automatic t_readonly();
    logic [31:0] v;
    pulse(1'b0, 1'b1);
    wr(2'd2, 32'h0000_1234);
    rd(2'd2, v); chk("R6 count write ignored", v, 32'd1);
  endtask

  task automatic t_irq();
    logic [31:0] v;
    wr(2'd3, 32'd3);
    wr(2'd0, 32'h0000_0037);
    repeat (2) pulse(1'b0, 1'b1);
    rd(2'd0, v); chk("R7 no status before match", {31'b0, v[3]}, 32'h0);
    chk("R9 irq low before match", {31'b0, irq}, 32'h0);
    pulse(1'b0, 1'b1);
    rd(2'd0, v); chk("R7 status on match", v, 32'h0000_001F);
    chk("R9 irq with enable", {31'b0, irq}, 32'h1);
    wr(2'd0, 32'h0000_0017);
    rd(2'd0, v); chk("R8 write 0 keeps status", {31'b0, v[3]}, 32'h1);
    wr(2'd0, 32'h0000_001F);
    rd(2'd0, v); chk("R8 write 1 clears status", {31'b0, v[3]}, 32'h0);
    chk("R9 irq drops on ack", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0000_0033);
    repeat (3) pulse(1'b0, 1'b1);
    rd(2'd0, v); chk("R7 status with enable off", {31'b0, v[3]}, 32'h1);
    chk("R9 irq masked", {31'b0, irq}, 32'h0);
    wr(2'd0, 32'h0000_002B);
    repeat (3) pulse(1'b0, 1'b1);
    rd(2'd0, v); chk("R7 unarmed no status", {31'b0, v[3]}, 32'h0);
    rd(2'd2, v); chk("R7 unarmed count reached", v, 32'd3);
    wr(2'd0, 32'h0000_0037);
    repeat (2) pulse(1'b0, 1'b1);
    wr_with_strobe(32'h0000_001F, 1'b0, 1'b1);
    rd(2'd0, v); chk("R8 set wins over ack", {31'b0, v[3]}, 32'h1);
    chk("R9 irq after collision", {31'b0, irq}, 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_regs();
    t_count_rate();
    t_hold();
    t_clear();
    t_readonly();
    t_irq();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule